// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a management-bus master for talking to external PHY devices over a two-wire serial link. It generates the MDC clock from the system clock and drives a tri-stated MDIO line through separate output, output-enable and input pins. It supports both the 22-style frame (start code 01) and the 45-style frame (start code 00) with its separate address cycle.

Software uses four 32-bit registers on a simple bus with single-cycle writes and combinational reads. The configuration register sets the MDC divider, the frame style and the MDC edge that launches MDIO data, and it reports busy and read-error status. A frame is never started by a separate command. Writing the address register sends an address frame (45-style only). Writing the data register sends a write frame. Writing the control register with its read bit set sends a read frame. Software polls the busy flag to learn when a frame has finished. After a read completes, the data register holds the PHY's reply.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero, and mdc, mdio_oe, busy (config bit 0) and read-error (config bit 1) are all low.
- R2: Register select comes from reg_addr[3:2]: 0 is config, 1 is control, 2 is data and 3 is address. Config reads back the divider in bits 15:8, the 45-style select in bit 6 and the falling-edge launch select in bit 23. Control reads back bits 4:0 (device/register number), bits 9:5 (PHY address) and bit 15 (read request). Data and address read back their low 16 bits.
- R3: MDC stays low while idle. During a frame it toggles every N system clocks, where N is config bits 15:8 and a value of 0 counts as 1. Each frame has exactly 64 rising MDC edges.
- R4: Writing the data register sends a 64-bit write frame, most significant bit first. The frame is 32 ones, then start code, then opcode, then the 5-bit PHY address (control 9:5), then the 5-bit device/register field (control 4:0), then turnaround 10, then the 16 data bits. In 22-style the start code is 01 and the write opcode is 01.
- R5: Writing control with bit 15 set sends a read frame. The 22-style read opcode is 10. The master releases MDIO (mdio_oe low) for frame bits 46 to 63. After busy clears, the data register holds the 16 bits the PHY drove in bits 48 to 63, most significant first.
- R6: In 45-style, writing the address register sends start 00, opcode 00 and the register's 16 bits as payload. In 22-style, an address-register write only stores the value and sends no frame.
- R7: In 45-style, a data-register write sends start 00 with opcode 01, and a read request sends start 00 with opcode 11.
- R8: If MDIO is high when sampled for the second turnaround bit (bit 47) of a read, the read-error flag is set when the frame completes and the data register reads 0xFFFF. The flag is cleared when the next read is launched.
- R9: Busy reads 1 from the cycle after a launching write until the final falling MDC edge of the frame. Any register write made while busy is set has no effect.
- R10: With config bit 23 set, MDIO changes only together with a falling MDC edge. With it clear, MDIO changes only together with a rising edge. In both modes the bit is sampled on the rising edge.
- R11: A config write, or a control write with bit 15 clear, starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is high |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line level, pulled up externally |

## Verification
The assertions assume that the divider field and the frame style do not change while a frame runs. This is true because writes are ignored while busy. They also assume that mdio_i settles at least one system clock before each rising MDC edge. The bench keeps within both assumptions. It polls busy before every new configuration. Its PHY model changes mdio_i only half a system clock after a rising MDC edge, so the level is stable for the whole period before the next sample. Random operations use dividers of 0 to 4 so that many frames fit in the run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_W     = 16;
  localparam int FLD_W      = 5;
  localparam int PRE_BITS   = 32;

  typedef enum logic [1:0] {SEL_CFG = 2'd0, SEL_CTL = 2'd1, SEL_DATA = 2'd2, SEL_ADDR = 2'd3} reg_sel_e;
  typedef enum logic [1:0] {FK_ADDR = 2'd0, FK_WRITE = 2'd1, FK_READ = 2'd2} frame_kind_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic c45, input frame_kind_e kind,
      input logic [FLD_W-1:0] phy, input logic [FLD_W-1:0] dev,
      input logic [DATA_W-1:0] payload);
    logic [1:0] st, op, ta;
    st = c45 ? 2'b00 : 2'b01;
    ta = (kind == FK_READ) ? 2'b11 : 2'b10;
    unique case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    return {{PRE_BITS{1'b1}}, st, op, phy, dev, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;
  logic             mdc_q, mdc_d, tick;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    tick    = run && (cnt_q == div_eff - DIV_W'(1));
    cnt_d   = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    mdc_d   = !run ? 1'b0 : (tick ? ~mdc_q : mdc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;

  // R3: after a mid-count cycle the clock level has held
  p_mdc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && cnt_q != '0 |-> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read,
  input  logic                  neg_edge,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_done,
  output logic                  no_resp,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(FRAME_BITS - DATA_W - 2);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(FRAME_BITS - DATA_W - 1);

  logic                  busy_q, busy_d, last_q, last_d, rd_q, rd_d, neg_q, neg_d, nr_q, nr_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [DATA_W-1:0]     sh_q, sh_d;

  always_comb begin
    busy_d = busy_q; last_d = last_q; rd_d = rd_q; neg_d = neg_q;
    nr_d = nr_q; idx_d = idx_q; frame_d = frame_q; sh_d = sh_q;
    if (start && !busy_q) begin
      busy_d = 1'b1; last_d = 1'b0; rd_d = is_read; neg_d = neg_edge;
      nr_d = 1'b0; idx_d = '0; frame_d = frame_in; sh_d = '0;
    end else if (busy_q) begin
      if (rise_stb) begin
        if (rd_q && idx_q == TA2_IDX) nr_d = mdio_i;
        if (rd_q && idx_q > TA2_IDX)  sh_d = {sh_q[DATA_W-2:0], mdio_i};
        if (idx_q == LAST_IDX)        last_d = 1'b1;
        else if (!neg_q)              idx_d = idx_q + IDX_W'(1);
      end
      if (fall_stb) begin
        if (last_q)     busy_d = 1'b0;
        else if (neg_q) idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; last_q <= 1'b0; rd_q <= 1'b0; neg_q <= 1'b0;
      nr_q <= 1'b0; idx_q <= '0; frame_q <= '0; sh_q <= '0;
    end else begin
      busy_q <= busy_d; last_q <= last_d; rd_q <= rd_d; neg_q <= neg_d;
      nr_q <= nr_d; idx_q <= idx_d; frame_q <= frame_d; sh_q <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = frame_q[LAST_IDX - idx_q];
  assign mdio_oe = busy_q && !(rd_q && idx_q >= TA1_IDX);
  assign rd_done = busy_q && fall_stb && last_q && rd_q;
  assign no_resp = nr_q;
  assign rd_data = sh_q;

  // R10: driven bit changes only right after the selected MDC edge
  p_neg_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && neg_q && mdio_oe && $past(mdio_oe) && !$stable(mdio_o)
    |-> $past(fall_stb));
  p_pos_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && !neg_q && mdio_oe && $past(mdio_oe) && !$stable(mdio_o)
    |-> $past(rise_stb));
  // R5: line released when the reply is sampled
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rd_q && rise_stb && idx_q > TA1_IDX |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DIV_LSB = 8;
  localparam int C45_BIT = 6;
  localparam int NEG_BIT = 23;
  localparam int RD_BIT  = 15;

  reg_sel_e              sel;
  logic                  busy, wr_ok, go_addr, go_wr, go_rd, start;
  logic                  rise_stb, fall_stb, rd_done, no_resp;
  logic [DATA_W-1:0]     rd_data;
  logic [FRAME_BITS-1:0] frame;
  frame_kind_e           kind;
  logic [DIV_W-1:0]      div_q, div_d;
  logic                  c45_q, c45_d, neg_q, neg_d, rdreq_q, rdreq_d, err_q, err_d;
  logic [FLD_W-1:0]      phy_q, phy_d, dev_q, dev_d;
  logic [DATA_W-1:0]     data_q, data_d, addr_q, addr_d;
  logic                  wdata_unused;

  assign sel          = reg_sel_e'(reg_addr[3:2]);
  assign wdata_unused = ^{reg_wdata[31:24], reg_wdata[22:16], reg_addr[1:0]};
  assign wr_ok        = reg_wr && !busy;
  assign go_addr      = wr_ok && sel == SEL_ADDR && c45_q;
  assign go_wr        = wr_ok && sel == SEL_DATA;
  assign go_rd        = wr_ok && sel == SEL_CTL && reg_wdata[RD_BIT];
  assign start        = go_addr || go_wr || go_rd;

  always_comb begin
    kind  = go_addr ? FK_ADDR : (go_rd ? FK_READ : FK_WRITE);
    frame = build_frame(c45_q, kind,
                        go_rd ? reg_wdata[2*FLD_W-1:FLD_W] : phy_q,
                        go_rd ? reg_wdata[FLD_W-1:0] : dev_q,
                        reg_wdata[DATA_W-1:0]);
  end

  always_comb begin
    div_d = div_q; c45_d = c45_q; neg_d = neg_q; rdreq_d = rdreq_q;
    phy_d = phy_q; dev_d = dev_q; data_d = data_q; addr_d = addr_q; err_d = err_q;
    if (wr_ok) begin
      unique case (sel)
        SEL_CFG: begin
          div_d = reg_wdata[DIV_LSB +: DIV_W];
          c45_d = reg_wdata[C45_BIT];
          neg_d = reg_wdata[NEG_BIT];
        end
        SEL_CTL: begin
          dev_d   = reg_wdata[FLD_W-1:0];
          phy_d   = reg_wdata[2*FLD_W-1:FLD_W];
          rdreq_d = reg_wdata[RD_BIT];
        end
        SEL_DATA: data_d = reg_wdata[DATA_W-1:0];
        default:  addr_d = reg_wdata[DATA_W-1:0];
      endcase
    end
    if (go_rd) err_d = 1'b0;
    if (rd_done) begin
      err_d  = no_resp;
      data_d = no_resp ? '1 : rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; c45_q <= 1'b0; neg_q <= 1'b0; rdreq_q <= 1'b0;
      phy_q <= '0; dev_q <= '0; data_q <= '0; addr_q <= '0; err_q <= 1'b0;
    end else begin
      div_q <= div_d; c45_q <= c45_d; neg_q <= neg_d; rdreq_q <= rdreq_d;
      phy_q <= phy_d; dev_q <= dev_d; data_q <= data_d; addr_q <= addr_d; err_q <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CFG: begin
        reg_rdata[0]                 = busy;
        reg_rdata[1]                 = err_q;
        reg_rdata[C45_BIT]           = c45_q;
        reg_rdata[DIV_LSB +: DIV_W]  = div_q;
        reg_rdata[NEG_BIT]           = neg_q;
      end
      SEL_CTL: begin
        reg_rdata[2*FLD_W-1:0] = {phy_q, dev_q};
        reg_rdata[RD_BIT]      = rdreq_q;
      end
      SEL_DATA: reg_rdata[DATA_W-1:0] = data_q;
      default:  reg_rdata[DATA_W-1:0] = addr_q;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb));

  mdio_frame_eng eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame), .is_read(go_rd),
    .neg_edge(neg_q), .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_done(rd_done),
    .no_resp(no_resp), .rd_data(rd_data));

  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_launch_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr |=> $stable({phy_q, dev_q, data_q, addr_q, div_q, c45_q, neg_q}));
  p_err_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(busy));
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, errors = 0;
  longint cyc = 0;

  // PHY model state (written only by the PHY process)
  logic        phy_drv = 1'b0, phy_val = 1'b0;
  logic        mdc_prev = 1'b0, line_prev = 1'b1, oe_prev = 1'b0, o_prev = 1'b0;
  logic [63:0] cap = '0;
  int          rise_n = 0, rises_total = 0, period_bad = 0, edge_bad = 0, oe_bad = 0;
  longint      last_rise = 0;
  // expectations (written only by the stimulus process)
  logic        exp_read = 1'b0, exp_neg = 1'b0, resp_en = 1'b1;
  int          exp_half = 1;
  logic [15:0] resp_data = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mdio_i = phy_drv ? phy_val : (mdio_oe ? mdio_o : 1'b1);

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(negedge clk) begin
    if (mdio_oe && !oe_prev) rise_n = 0;
    if (mdc && !mdc_prev) begin
      if (rise_n < 64) cap[63-rise_n] = line_prev;
      if (rise_n > 0 && (cyc - last_rise) != longint'(2*exp_half)) period_bad++;
      last_rise = cyc;
      if (exp_read && rise_n >= 46 && oe_prev) oe_bad++;
      phy_drv = 1'b0;
      if (exp_read && resp_en) begin
        if (rise_n + 1 == 47) begin phy_drv = 1'b1; phy_val = 1'b0; end
        else if (rise_n + 1 >= 48 && rise_n + 1 <= 63) begin
          phy_drv = 1'b1; phy_val = resp_data[15-(rise_n+1-48)];
        end
      end
      rise_n++;
      rises_total++;
    end
    if (mdio_oe && oe_prev && mdio_o != o_prev)
      if (exp_neg ? !(mdc_prev && !mdc) : !(!mdc_prev && mdc)) edge_bad++;
    mdc_prev  = mdc;
    oe_prev   = mdio_oe;
    o_prev    = mdio_o;
    line_prev = phy_drv ? phy_val : (mdio_oe ? mdio_o : 1'b1);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(4'h0, v);
      if (!v[0]) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cfg_word(input logic [7:0] div, input logic c45, input logic neg);
    logic [31:0] v = '0;
    v[15:8] = div; v[6] = c45; v[23] = neg;
    return v;
  endfunction

  // kind: 0 address, 1 write, 2 read
  function automatic logic [63:0] exp_frame(input logic c45, input int kind,
      input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] pay);
    logic [1:0] st = c45 ? 2'b00 : 2'b01;
    logic [1:0] op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
    return {32'hFFFF_FFFF, st, op, phy, dev, 2'b10, pay};
  endfunction

  logic cur_c45 = 1'b0;

  task automatic configure(input logic [7:0] div, input logic c45, input logic neg);
    wr(4'h0, cfg_word(div, c45, neg));
    exp_half = (div == 0) ? 1 : int'(div);
    exp_neg  = neg;
    cur_c45  = c45;
  endtask

  task automatic run_op(input int kind, input logic [4:0] phy, input logic [4:0] dev,
                        input logic [15:0] pay, input logic respond, input string req);
    logic [31:0] v;
    logic [63:0] ef, mask;
    int pb = period_bad, eb = edge_bad, ob = oe_bad;
    exp_read  = (kind == 2);
    resp_en   = respond;
    resp_data = pay;
    if (kind != 2) wr(4'h4, {22'd0, phy, dev});
    if (kind == 0) wr(4'hC, {16'd0, pay});
    else if (kind == 1) wr(4'h8, {16'd0, pay});
    else wr(4'h4, {16'd0, 1'b1, 5'd0, phy, dev});
    rd(4'h0, v);
    chk(v[0] == 1'b1, {req, " R9 busy after launch"}, 64'(v[0]), 64'd1);
    wait_idle();
    chk(rise_n == 64, {req, " R3 rising edges"}, 64'(rise_n), 64'd64);
    chk(period_bad == pb, {req, " R3 MDC period"}, 64'(period_bad - pb), 64'd0);
    chk(edge_bad == eb, {req, " R10 launch edge"}, 64'(edge_bad - eb), 64'd0);
    ef   = exp_frame(cur_c45, kind, phy, dev, pay);
    mask = (kind == 2) ? {{46{1'b1}}, 18'd0} : '1;
    chk(((cap ^ ef) & mask) == 0, {req, " R4 frame bits"}, cap, ef);
    if (kind == 2) begin
      chk(oe_bad == ob, {req, " R5 line released"}, 64'(oe_bad - ob), 64'd0);
      rd(4'h8, v);
      chk(v[15:0] == (respond ? pay : 16'hFFFF), {req, " R5 R8 read data"}, 64'(v[15:0]),
          64'(respond ? pay : 16'hFFFF));
      rd(4'h0, v);
      chk(v[1] == !respond, {req, " R8 read error flag"}, 64'(v[1]), 64'(!respond));
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, {req, " R3 idle lines"}, 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk(v == 0, "R1 config reset", 64'(v), 0);
    rd(4'h4, v); chk(v == 0, "R1 control reset", 64'(v), 0);
    rd(4'h8, v); chk(v == 0, "R1 data reset", 64'(v), 0);
    chk(mdc == 0 && mdio_oe == 0, "R1 lines at reset", 64'({mdc, mdio_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); chk(v == 0, "R1 config after release", 64'(v), 0);

    // R2 / R11: config and control writes start nothing
    base = rises_total;
    configure(8'd3, 1'b0, 1'b1);
    rd(4'h0, v); chk(v == cfg_word(8'd3, 1'b0, 1'b1), "R2 config readback", 64'(v), 64'(cfg_word(8'd3, 1'b0, 1'b1)));
    wr(4'h4, 32'h0000_02A5);
    rd(4'h4, v); chk(v == 32'h0000_02A5, "R2 control readback", 64'(v), 64'h2A5);
    // R6: address write in 22-style only stores
    wr(4'hC, 32'h0000_BEEF);
    rd(4'hC, v); chk(v == 32'h0000_BEEF, "R2 R6 address readback", 64'(v), 64'hBEEF);
    repeat (40) @(negedge clk);
    rd(4'h0, v);
    chk(rises_total == base && v[0] == 0, "R11 R6 no frame started", 64'(rises_total - base), 0);

    // directed 22-style frames
    run_op(1, 5'h11, 5'h04, 16'hA5C3, 1'b1, "c22 write");
    run_op(2, 5'h03, 5'h1F, 16'h5A3C, 1'b1, "c22 read");
    run_op(2, 5'h07, 5'h02, 16'h1234, 1'b0, "c22 read no reply R8");
    run_op(2, 5'h07, 5'h02, 16'h8001, 1'b1, "c22 read clears error R8");
    configure(8'd0, 1'b0, 1'b0);
    run_op(1, 5'h1F, 5'h00, 16'hFFFE, 1'b1, "div zero rising launch R3 R10");

    // 45-style frames
    configure(8'd2, 1'b1, 1'b1);
    run_op(0, 5'h02, 5'h1E, 16'h0C0D, 1'b1, "c45 address R6");
    run_op(1, 5'h02, 5'h1E, 16'h7777, 1'b1, "c45 write R7");
    run_op(2, 5'h02, 5'h1E, 16'hC3A5, 1'b1, "c45 read R7");

    // R9: writes while busy are ignored
    wr(4'h4, 32'h0000_0123);
    wr(4'h8, 32'h0000_4444);
    wr(4'h4, 32'h0000_83FF);
    wr(4'h8, 32'h0000_9999);
    wr(4'h0, cfg_word(8'd9, 1'b0, 1'b0));
    wait_idle();
    repeat (20) @(negedge clk);
    rd(4'h4, v); chk(v == 32'h0000_0123, "R9 control kept", 64'(v), 64'h123);
    rd(4'h8, v); chk(v == 32'h0000_4444, "R9 data kept", 64'(v), 64'h4444);
    rd(4'h0, v); chk(v == cfg_word(8'd2, 1'b1, 1'b1), "R9 config kept", 64'(v), 64'(cfg_word(8'd2, 1'b1, 1'b1)));
    chk(rise_n == 64, "R9 single frame", 64'(rise_n), 64);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic c45 = 1'($urandom);
      int k = int'($urandom % 3);
      if (!c45 && k == 0) k = 1;
      configure(8'($urandom % 5), c45, 1'($urandom));
      run_op(k, 5'($urandom), 5'($urandom), 16'($urandom), ($urandom % 4) != 0, "random R4 R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule